// File: doc/BRIEF.md
# Multi-Domain Reset and Pad Override Controller

This block owns reset for a small communications device built from three functional domains: a serial frame-bus handler, a voice codec and a line transceiver. One asynchronous active-low external reset puts the whole device into hardware reset. A host-written soft-reset register holds one level-sensitive bit per domain. The block drives one active-low reset per domain and a chip-level reset output. It also places each pad of a domain in a defined state while that domain is held in reset. The clocks are never gated here and keep running through every kind of reset.

The external reset passes through a two-flop synchroniser in the system clock domain. It asserts at once and deasserts on a clock edge. The chip-level reset output then stays asserted until a bit-clock falling edge. The bit clock is sampled by the system clock, and only a falling edge seen after the synchronised reset has released counts. Each pad is a value/enable pair. The functional logic supplies the normal pair. The block passes that pair through, or replaces it with a forced level or a killed output enable while the pad's domain is in reset.

Pad index map: 0 frame sync, 1 first data strobe, 2 bit-clock pad, 3 downstream data, 4 upstream data, 5..8 codec analog outputs (speaker +/-, handset +/-), 9..12 line transceiver pins, 13 serial data out, 14 interrupt.

Top module: `mdom_reset_ctl`

## Requirements
- R1: While `ext_rst_n` is 0, `rst_out_n` is 0 without waiting for a clock edge, and every bit of `dom_rst_n` is 0.
- R2: After `ext_rst_n` rises, `rst_out_n` rises on the second `clk` edge after the first `bclk_in` fall that occurs once the two-stage synchroniser has released. A `bclk_in` fall before that point does not release it. Once released, `rst_out_n` stays 1 until the next external reset.
- R3: While `rst_out_n` is 0, the soft-reset register is held at 0 and writes to it are ignored.
- R4: A write (`sw_wr_en`=1 at a `clk` edge) loads the soft-reset bits. Bit 0 is the frame-bus handler, bit 1 the codec and bit 2 the transceiver. `dom_rst_n[i]` is 0 from that edge for as long as bit i is 1, and returns to 1 when bit i is written 0. The other domains are not affected.
- R5: `sw_rd_data` returns the three stored bits in positions 2..0. Bits 7..3 always read 0, whatever was written to them.
- R6: While `dom_rst_n[0]` is 0, pad 0 is driven 1 and pad 1 is driven 0, both with enable 1. Pads 2, 3 and 4 have enable 0.
- R7: While `dom_rst_n[1]` is 0, pads 5..8 have enable 0.
- R8: While `dom_rst_n[2]` is 0, pads 9..12 have enable 0.
- R9: Pads 13 and 14 have enable 0 while `rst_out_n` is 0 and are not affected by soft-reset bits.
- R10: A pad that is not forced by a reset in progress shows `func_val`/`func_oe` unchanged. A pad whose only override is an enable kill keeps its `func_val` value.
- R11: Each `dom_rst_n[i]` is 0 whenever `rst_out_n` is 0, whatever the soft-reset bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| ext_rst_n | input | 1 | Asynchronous external reset, active low |
| bclk_in | input | 1 | Bit clock, sampled to find its falling edge |
| sw_wr_en | input | 1 | Soft-reset register write strobe |
| sw_wr_data | input | 8 | Soft-reset register write value |
| sw_rd_data | output | 8 | Soft-reset register read value |
| func_val | input | 15 | Functional pad output values |
| func_oe | input | 15 | Functional pad output enables |
| rst_out_n | output | 1 | Chip-level reset output, active low |
| dom_rst_n | output | 3 | Per-domain resets, active low |
| pad_val | output | 15 | Pad output values after override |
| pad_oe | output | 15 | Pad output enables after override |

## Verification
Entry into external reset is combinational, so the bench samples `rst_out_n` 1 ns after it drops `ext_rst_n`. Release takes two clock edges after the bit clock falls, one for the sampling register and one for the release flop. The bench checks that the output is still low after the first of these edges and high after the second. Register writes take effect on the write edge, and the pad overrides follow combinationally from the domain resets. The table walk therefore drives each write half a cycle before an edge and checks read data, domain resets and every pad at the following falling clock edge.

// File: rtl/mdom_reset_pkg.sv
// Package: shared sizes, pad index map and per-pad override rules for the
// multi-domain reset controller. Assumes a fixed pad order that the pad
// ring wiring depends on.
package mdom_reset_pkg;

    localparam int NDOM       = 3;
    localparam int DOM_FBUS   = 0;
    localparam int DOM_CODEC  = 1;
    localparam int DOM_LINE   = 2;

    localparam int REG_W      = 8;

    localparam int FB_PINS    = 5;
    localparam int CODEC_PINS = 4;
    localparam int LINE_PINS  = 4;
    localparam int HW_PINS    = 2;

    localparam int FB_BASE    = 0;
    localparam int CODEC_BASE = FB_BASE + FB_PINS;
    localparam int LINE_BASE  = CODEC_BASE + CODEC_PINS;
    localparam int HW_BASE    = LINE_BASE + LINE_PINS;
    localparam int NPINS      = HW_BASE + HW_PINS;

    localparam int PIN_FSYNC  = FB_BASE + 0;
    localparam int PIN_STRB1  = FB_BASE + 1;
    localparam int PIN_SDO    = HW_BASE + 0;
    localparam int PIN_IRQ    = HW_BASE + 1;

    typedef enum logic [1:0] {
        GRP_FBUS   = 2'd0,
        GRP_CODEC  = 2'd1,
        GRP_LINE   = 2'd2,
        GRP_HWONLY = 2'd3
    } pin_grp_e;

    typedef enum logic [1:0] {
        OVR_TRI  = 2'd0,
        OVR_HIGH = 2'd1,
        OVR_LOW  = 2'd2
    } pin_ovr_e;

    // Which reset source governs a pad.
    function automatic pin_grp_e pin_group(input int p);
        if (p < CODEC_BASE)     return GRP_FBUS;
        else if (p < LINE_BASE) return GRP_CODEC;
        else if (p < HW_BASE)   return GRP_LINE;
        else                    return GRP_HWONLY;
    endfunction

    // What a pad does while its reset source is active.
    function automatic pin_ovr_e pin_override(input int p);
        if (p == PIN_FSYNC)      return OVR_HIGH;
        else if (p == PIN_STRB1) return OVR_LOW;
        else                     return OVR_TRI;
    endfunction

    // Domain index of a domain-governed pad group.
    function automatic int grp_domain(input pin_grp_e g);
        case (g)
            GRP_FBUS:  return DOM_FBUS;
            GRP_CODEC: return DOM_CODEC;
            default:   return DOM_LINE;
        endcase
    endfunction

endpackage

// File: rtl/mdom_rst_sync.sv
// Module: reset synchroniser. Asserts its output asynchronously when the
// external reset pin goes low and releases it after STAGES clock edges.
// Assumes clk keeps running during reset. This is the one place where an
// asynchronous reset is used; everything downstream resets synchronously.
module mdom_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic sync_rst_n
);

    logic [STAGES-1:0] chain_q;

    // Shift ones in after release; clear the whole chain on assertion.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], 1'b1};
        end
    end

    assign sync_rst_n = chain_q[STAGES-1];

endmodule

// File: rtl/mdom_rst_release.sv
// Module: chip reset release. Samples the bit clock in the system clock
// domain, finds its falling edge and holds the chip-level reset asserted
// until the first such edge seen after the synchronised reset has released.
// Assumes the bit clock is much slower than clk.
module mdom_rst_release (
    input  logic clk,
    input  logic hw_sync_n,
    input  logic bclk_in,
    output logic rst_out_n
);

    logic bclk_s;
    logic bclk_d;
    logic bclk_fall;
    logic rel_q;

    // Sample the bit clock and keep a delayed copy; runs through reset.
    always_ff @(posedge clk) begin
        bclk_s <= bclk_in;
        bclk_d <= bclk_s;
    end

    assign bclk_fall = bclk_d & ~bclk_s;

    // Release flag: cleared by hardware reset, set once by a bit-clock fall.
    always_ff @(posedge clk) begin
        if (!hw_sync_n) begin
            rel_q <= 1'b0;
        end else if (bclk_fall) begin
            rel_q <= 1'b1;
        end
    end

    assign rst_out_n = hw_sync_n & rel_q;

    AST_REL_NEEDS_FALL: assert property (@(posedge clk) disable iff (!hw_sync_n)
        $rose(rel_q) |-> $past(bclk_fall)); // R2
    AST_REL_STICKY: assert property (@(posedge clk) disable iff (!hw_sync_n)
        rel_q |=> rel_q); // R2

endmodule

// File: rtl/mdom_swrst_reg.sv
// Module: soft-reset register. One level-held bit per domain, written
// through a strobe and data port and read back with reserved bits at 0.
// Assumes rst_n is the chip-level reset, so it clears synchronously for the
// whole hardware reset window.
module mdom_swrst_reg
    import mdom_reset_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output logic [NDOM-1:0]   soft_bits
);

    logic [NDOM-1:0] bits_q;
    logic            unused_rsv;

    // Hold the domain bits; hardware reset wins over a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (wr_en) begin
            bits_q <= wr_data[NDOM-1:0];
        end
    end

    // Read value: stored bits at the bottom, reserved field zero.
    always_comb begin
        rd_data             = '0;
        rd_data[NDOM-1:0]   = bits_q;
    end

    assign soft_bits  = bits_q;
    assign unused_rsv = ^wr_data[REG_W-1:NDOM];

    AST_SW_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (soft_bits == '0)); // R3
    AST_SW_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[NDOM-1:0] == $past(wr_data[NDOM-1:0]))); // R4

endmodule

// File: rtl/mdom_pad_ovr.sv
// Module: pad override. For every pad, picks its governing reset and
// either passes the functional value/enable pair or applies the pad's
// reset behaviour (forced level or killed enable). Purely combinational.
module mdom_pad_ovr
    import mdom_reset_pkg::*;
(
    input  logic [NDOM-1:0]  dom_rst_n,
    input  logic             hw_rst_n,
    input  logic [NPINS-1:0] func_val,
    input  logic [NPINS-1:0] func_oe,
    output logic [NPINS-1:0] pad_val,
    output logic [NPINS-1:0] pad_oe
);

    for (genvar p = 0; p < NPINS; p++) begin : g_pad
        localparam pin_grp_e GRP = pin_group(p);
        localparam pin_ovr_e OVR = pin_override(p);

        logic in_rst;

        if (GRP == GRP_HWONLY) begin : g_hw
            assign in_rst = ~hw_rst_n;
        end else begin : g_dom
            localparam int DOM = grp_domain(GRP);
            assign in_rst = ~dom_rst_n[DOM];
        end

        // Apply the pad's reset behaviour when its source is active.
        always_comb begin
            pad_val[p] = func_val[p];
            pad_oe[p]  = func_oe[p];
            if (in_rst) begin
                case (OVR)
                    OVR_HIGH: begin
                        pad_val[p] = 1'b1;
                        pad_oe[p]  = 1'b1;
                    end
                    OVR_LOW: begin
                        pad_val[p] = 1'b0;
                        pad_oe[p]  = 1'b1;
                    end
                    default: begin
                        pad_oe[p]  = 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/mdom_reset_ctl.sv
// Module: top of the multi-domain reset controller. Synchronises the
// external reset, times the chip reset release to the bit clock, holds the
// soft-reset register, combines hardware and soft resets per domain and
// applies pad overrides. Assumes clk and bclk_in run during reset.
module mdom_reset_ctl
    import mdom_reset_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              ext_rst_n,
    input  logic              bclk_in,
    input  logic              sw_wr_en,
    input  logic [REG_W-1:0]  sw_wr_data,
    output logic [REG_W-1:0]  sw_rd_data,
    input  logic [NPINS-1:0]  func_val,
    input  logic [NPINS-1:0]  func_oe,
    output logic              rst_out_n,
    output logic [NDOM-1:0]   dom_rst_n,
    output logic [NPINS-1:0]  pad_val,
    output logic [NPINS-1:0]  pad_oe
);

    logic            hw_sync_n;
    logic [NDOM-1:0] soft_bits;

    mdom_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .arst_n     (ext_rst_n),
        .sync_rst_n (hw_sync_n)
    );

    mdom_rst_release u_release (
        .clk       (clk),
        .hw_sync_n (hw_sync_n),
        .bclk_in   (bclk_in),
        .rst_out_n (rst_out_n)
    );

    mdom_swrst_reg u_swreg (
        .clk       (clk),
        .rst_n     (rst_out_n),
        .wr_en     (sw_wr_en),
        .wr_data   (sw_wr_data),
        .rd_data   (sw_rd_data),
        .soft_bits (soft_bits)
    );

    // Domain reset is active when either hardware or its soft bit asks.
    always_comb begin
        for (int d = 0; d < NDOM; d++) begin
            dom_rst_n[d] = rst_out_n & ~soft_bits[d];
        end
    end

    mdom_pad_ovr u_pads (
        .dom_rst_n (dom_rst_n),
        .hw_rst_n  (rst_out_n),
        .func_val  (func_val),
        .func_oe   (func_oe),
        .pad_val   (pad_val),
        .pad_oe    (pad_oe)
    );

    AST_HW_KILLS_SDO_IRQ: assert property (@(posedge clk) disable iff (!ext_rst_n)
        !rst_out_n |-> (!pad_oe[PIN_SDO] && !pad_oe[PIN_IRQ])); // R9
    AST_HW_HOLDS_DOMAINS: assert property (@(posedge clk) disable iff (!ext_rst_n)
        !rst_out_n |-> (dom_rst_n == '0)); // R11
    AST_FSYNC_FORCED: assert property (@(posedge clk) disable iff (!ext_rst_n)
        !dom_rst_n[DOM_FBUS] |-> (pad_val[PIN_FSYNC] && pad_oe[PIN_FSYNC])); // R6

endmodule

// File: tb/tb_mdom_reset_ctl.sv
module tb_mdom_reset_ctl;

    localparam time CLK_P = 10ns;
    localparam int  NP    = 15;

    typedef struct packed {
        logic [7:0]    wdata;
        logic [NP-1:0] fval;
        logic [NP-1:0] foe;
        logic [7:0]    exp_rd;
        logic [2:0]    exp_dom_n;
    } vec_t;

    // Table: soft-reset write, functional pads, expected read and domains.
    localparam vec_t TBL [8] = '{
        '{8'h00, 15'h7FFF, 15'h7FFF, 8'h00, 3'b111},
        '{8'h01, 15'h0000, 15'h7FFF, 8'h01, 3'b110},
        '{8'h02, 15'h5555, 15'h7FFF, 8'h02, 3'b101},
        '{8'h04, 15'h2AAA, 15'h7FFF, 8'h04, 3'b011},
        '{8'h05, 15'h7FFF, 15'h0000, 8'h05, 3'b010},
        '{8'hFF, 15'h1234, 15'h4321, 8'h07, 3'b000},
        '{8'hF8, 15'h0F0F, 15'h70F0, 8'h00, 3'b111},
        '{8'h03, 15'h7FFF, 15'h7FFF, 8'h03, 3'b100}
    };

    logic          clk = 1'b0;
    logic          ext_rst_n;
    logic          bclk_in;
    logic          sw_wr_en;
    logic [7:0]    sw_wr_data;
    logic [7:0]    sw_rd_data;
    logic [NP-1:0] func_val;
    logic [NP-1:0] func_oe;
    logic          rst_out_n;
    logic [2:0]    dom_rst_n;
    logic [NP-1:0] pad_val;
    logic [NP-1:0] pad_oe;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_P/2) clk = ~clk;

    mdom_reset_ctl dut (
        .clk        (clk),
        .ext_rst_n  (ext_rst_n),
        .bclk_in    (bclk_in),
        .sw_wr_en   (sw_wr_en),
        .sw_wr_data (sw_wr_data),
        .sw_rd_data (sw_rd_data),
        .func_val   (func_val),
        .func_oe    (func_oe),
        .rst_out_n  (rst_out_n),
        .dom_rst_n  (dom_rst_n),
        .pad_val    (pad_val),
        .pad_oe     (pad_oe)
    );

    task automatic check(input bit ok, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Expected pads from the requirement rules (R6..R10).
    task automatic exp_pads(input logic [2:0] dn, input bit hw, input logic [NP-1:0] fv,
                            input logic [NP-1:0] fo, output logic [NP-1:0] ev,
                            output logic [NP-1:0] eo);
        ev = fv;
        eo = fo;
        if (!dn[0]) begin
            ev[0] = 1'b1; eo[0] = 1'b1;
            ev[1] = 1'b0; eo[1] = 1'b1;
            eo[2] = 1'b0; eo[3] = 1'b0; eo[4] = 1'b0;
        end
        if (!dn[1]) for (int i = 5; i <= 8; i++) eo[i] = 1'b0;
        if (!dn[2]) for (int i = 9; i <= 12; i++) eo[i] = 1'b0;
        if (hw) begin
            eo[13] = 1'b0; eo[14] = 1'b0;
        end
    endtask

    task automatic check_pads(input string tag, input bit hw);
        logic [NP-1:0] ev, eo;
        exp_pads(dom_rst_n, hw, func_val, func_oe, ev, eo);
        check(pad_val == ev, {tag, " pad_val"}, 32'(pad_val), 32'(ev));
        check(pad_oe == eo, {tag, " pad_oe"}, 32'(pad_oe), 32'(eo));
    endtask

    task automatic sw_write(input logic [7:0] d);
        @(negedge clk);
        sw_wr_en   = 1'b1;
        sw_wr_data = d;
        @(posedge clk);
        @(negedge clk);
        sw_wr_en   = 1'b0;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Release with bit clock low, then one fall; checks R2 timing.
    task automatic release_reset();
        @(negedge clk);
        bclk_in   = 1'b0;
        cycles(3);
        ext_rst_n = 1'b1;
        cycles(8);
        check(rst_out_n == 1'b0, "R2 held without bclk fall", 32'(rst_out_n), 0);
        bclk_in = 1'b1;
        cycles(3);
        bclk_in = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(rst_out_n == 1'b0, "R2 one edge after fall", 32'(rst_out_n), 0);
        @(posedge clk);
        @(negedge clk);
        check(rst_out_n == 1'b1, "R2 released two edges after fall", 32'(rst_out_n), 1);
    endtask

    initial begin
        #(CLK_P * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        ext_rst_n  = 1'b0;
        bclk_in    = 1'b0;
        sw_wr_en   = 1'b0;
        sw_wr_data = '0;
        func_val   = 15'h7FFF;
        func_oe    = 15'h7FFF;
        cycles(5);

        // Reset state (R1, R3, R6..R9, R11).
        check(rst_out_n == 1'b0, "R1 rst_out_n in reset", 32'(rst_out_n), 0);
        check(dom_rst_n == 3'b000, "R1 R11 domains in reset", 32'(dom_rst_n), 0);
        check(sw_rd_data == 8'h00, "R3 register reset value", 32'(sw_rd_data), 0);
        check_pads("R6 R7 R8 R9 hw reset", 1'b1);

        // Bit-clock fall while external reset is still low: no release (R2).
        bclk_in = 1'b1;
        cycles(2);
        bclk_in = 1'b0;
        cycles(3);
        check(rst_out_n == 1'b0, "R2 fall during ext reset", 32'(rst_out_n), 0);

        release_reset();

        // Writes during the hardware window were ignored; now clear (R3).
        check(sw_rd_data == 8'h00, "R3 register after release", 32'(sw_rd_data), 0);
        check(dom_rst_n == 3'b111, "R4 domains out of reset", 32'(dom_rst_n), 7);

        // Further bit-clock toggles keep the release (R2).
        bclk_in = 1'b1;
        cycles(2);
        bclk_in = 1'b0;
        cycles(3);
        check(rst_out_n == 1'b1, "R2 stays released", 32'(rst_out_n), 1);

        // Table walk (R4, R5, R6..R10).
        foreach (TBL[k]) begin
            sw_write(TBL[k].wdata);
            func_val = TBL[k].fval;
            func_oe  = TBL[k].foe;
            #1;
            check(sw_rd_data == TBL[k].exp_rd, $sformatf("R5 readback row %0d", k),
                  32'(sw_rd_data), 32'(TBL[k].exp_rd));
            check(dom_rst_n == TBL[k].exp_dom_n, $sformatf("R4 domains row %0d", k),
                  32'(dom_rst_n), 32'(TBL[k].exp_dom_n));
            check_pads($sformatf("R6 R7 R8 R9 R10 row %0d", k), 1'b0);
        end

        // Soft bits held across idle cycles (R4).
        cycles(6);
        check(dom_rst_n == 3'b100, "R4 level held", 32'(dom_rst_n), 4);

        // External reset entry is immediate (R1) and overrides soft bits (R11).
        @(negedge clk);
        ext_rst_n = 1'b0;
        #1;
        check(rst_out_n == 1'b0, "R1 immediate assertion", 32'(rst_out_n), 0);
        check(dom_rst_n == 3'b000, "R11 all domains", 32'(dom_rst_n), 0);
        check_pads("R9 hw reset again", 1'b1);

        // Write attempt inside the reset window is lost (R3).
        sw_write(8'h07);
        check(sw_rd_data == 8'h00, "R3 write ignored in reset", 32'(sw_rd_data), 0);

        release_reset();
        check(sw_rd_data == 8'h00, "R3 cleared by hw reset", 32'(sw_rd_data), 0);
        check(dom_rst_n == 3'b111, "R11 domains released", 32'(dom_rst_n), 7);
        check_pads("R10 passthrough after reset", 1'b0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule